// File: doc/BRIEF.md
# Host Command and Video Stream Controller

This block sits between a byte-wide link to a host computer and the capture side of a video path. It takes single-byte commands from the host on a receive stream. It answers a format query with a short fixed packet, and it switches the camera capture unit on and off through a streaming-enable output. While streaming is on, it passes bytes from the frame FIFO to the byte-wide transmit stream, and it waits whenever the transmit side is not ready.

The frame FIFO is a show-ahead FIFO. Its head byte is visible on `fifo_data` whenever `fifo_empty` is low, and a pulse on `fifo_rd_en` removes that byte. The transmit side uses a valid/ready handshake, and a byte moves on a clock edge where `tx_valid` and `tx_ready` are both high. Receive bytes are taken on every cycle in which `rx_valid` is high. Parameters set the image width, the image height and the colour mode: 1 means grayscale and 2 means RGB565.

Top module: `host_stream_ctrl`

## Requirements
- R1: After reset, `stream_en`, `tx_valid` and `fifo_rd_en` are all low, and the block is idle.
- R2: In idle, command 0x01 sends a packet of exactly five bytes. Its first byte is 0xAA when COLOR_MODE is 1 (grayscale) and 0xBB when COLOR_MODE is 2 (RGB565).
- R3: Packet bytes 1 and 2 hold IMG_W and bytes 3 and 4 hold IMG_H, each as 16 bits with the most significant byte first.
- R4: While `tx_valid` is high and `tx_ready` is low, the next cycle still has `tx_valid` high with `tx_data` unchanged.
- R5: In idle, command 0x11 raises `stream_en` on the following cycle.
- R6: While streaming, FIFO bytes leave on `tx_data` in FIFO order, and `fifo_rd_en` is high exactly in the cycles where a transmit handshake takes place.
- R7: Command 0x0F while streaming drops `stream_en` on the next cycle. Every FIFO byte not yet sent is then popped and discarded with `tx_valid` low, and the block returns to idle.
- R8: Command bytes other than 0x01, 0x11 and 0x0F have no effect in any state. Command 0x01 has no effect while streaming. Any command that arrives while a packet is being sent has no effect.
- R9: `fifo_rd_en` is never high while `fifo_empty` is high.
- R10: If 0x0F arrives while a FIFO byte is being offered but has not been accepted, that byte stays on `tx_data` until it is accepted, and only then is the rest of the FIFO discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A command byte is present |
| rx_data | input | 8 | Command byte |
| tx_valid | output | 1 | A transmit byte is offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit side accepts the byte |
| stream_en | output | 1 | Capture enable for the camera side |
| fifo_rd_en | output | 1 | Pops the FIFO head byte |
| fifo_data | input | 8 | FIFO head byte (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no data |

## Verification
On every cycle, the assertions check four things: the transmit byte is held stable under back-pressure, the empty FIFO is never popped, a start command enables streaming on the next cycle, and a stop command (or an ignored 0x01) changes streaming on the next cycle or not at all. Some behaviour only the bench scenarios can show. These are the exact contents and length of the format packet for both colour modes, and the in-order forwarding of randomly timed FIFO traffic under random back-pressure. They also cover the discard of leftover FIFO data after a stop, including a stop that arrives while a byte is still being offered.

// File: rtl/host_stream_ctrl.sv
module host_stream_ctrl #(
  parameter int IMG_W      = 640,
  parameter int IMG_H      = 480,
  parameter int COLOR_MODE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       stream_en,
  output logic       fifo_rd_en,
  input  logic [7:0] fifo_data,
  input  logic       fifo_empty
);

  localparam logic [7:0]  OP_QUERY  = 8'h01;
  localparam logic [7:0]  OP_GO     = 8'h11;
  localparam logic [7:0]  OP_HALT   = 8'h0F;
  localparam logic [7:0]  KIND_BYTE = (COLOR_MODE == 1) ? 8'hAA : 8'hBB;
  localparam logic [15:0] W16       = 16'(IMG_W);
  localparam logic [15:0] H16       = 16'(IMG_H);
  localparam logic [2:0]  LAST_IDX  = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_INFO, S_STREAM, S_FLUSH} state_t;

  state_t     st;
  logic [2:0] idx;
  logic       halt_pend;
  logic [7:0] info_byte;

  wire query = rx_valid && (rx_data == OP_QUERY);
  wire go    = rx_valid && (rx_data == OP_GO);
  wire halt  = rx_valid && (rx_data == OP_HALT);
  wire hs    = tx_valid && tx_ready;

  always_comb begin
    case (idx)
      3'd0:    info_byte = KIND_BYTE;
      3'd1:    info_byte = W16[15:8];
      3'd2:    info_byte = W16[7:0];
      3'd3:    info_byte = H16[15:8];
      default: info_byte = H16[7:0];
    endcase
  end

  assign tx_valid   = (st == S_INFO) || (st == S_STREAM && !fifo_empty);
  assign tx_data    = (st == S_INFO) ? info_byte : fifo_data;
  assign fifo_rd_en = (st == S_STREAM && hs) || (st == S_FLUSH && !fifo_empty);
  assign stream_en  = (st == S_STREAM) && !halt_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      halt_pend <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          idx <= '0;
          if (query)   st <= S_INFO;
          else if (go) st <= S_STREAM;
        end
        S_INFO: begin
          if (hs) begin
            if (idx == LAST_IDX) begin
              st  <= S_IDLE;
              idx <= '0;
            end else begin
              idx <= idx + 3'd1;
            end
          end
        end
        S_STREAM: begin
          if (halt_pend) begin
            if (hs) begin
              st        <= S_FLUSH;
              halt_pend <= 1'b0;
            end
          end else if (halt) begin
            if (tx_valid && !tx_ready) halt_pend <= 1'b1;
            else                       st        <= S_FLUSH;
          end
        end
        S_FLUSH: begin
          if (fifo_empty) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R4
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> !fifo_empty); // R9
  AST_GO_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && go |=> stream_en); // R5
  AST_HALT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    stream_en && halt |=> !stream_en); // R7
  AST_QUERY_IGNORED_STREAMING: assert property (@(posedge clk) disable iff (!rst_n)
    stream_en && query |=> stream_en); // R8

endmodule

// File: tb/host_stream_ctrl_tb.sv
module host_stream_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 640;
  localparam int H = 480;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, tx_ready = 0, fifo_empty = 1;
  logic [7:0] rx_data = 0, fifo_data = 0;
  logic tx_valid, stream_en, fifo_rd_en;
  logic [7:0] tx_data;
  logic r_tx_valid, r_stream_en, r_fifo_rd_en;
  logic [7:0] r_tx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] q[$], pushed[$], got[$], got_rgb[$];
  bit cap_on = 0, mode_stream = 0;
  logic prev_v = 0, prev_r = 0;
  logic [7:0] prev_d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_stream_ctrl #(.IMG_W(W), .IMG_H(H), .COLOR_MODE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .stream_en(stream_en), .fifo_rd_en(fifo_rd_en),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty));

  host_stream_ctrl #(.IMG_W(W), .IMG_H(H), .COLOR_MODE(2)) dut_rgb (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(r_tx_valid), .tx_data(r_tx_data), .tx_ready(1'b1),
    .stream_en(r_stream_en), .fifo_rd_en(r_fifo_rd_en),
    .fifo_data(8'h00), .fifo_empty(1'b1));

  function automatic logic [7:0] exp_info(int mode, int i);
    case (i)
      0: return (mode == 1) ? 8'hAA : 8'hBB;
      1: return 8'((W >> 8) & 255);
      2: return 8'(W & 255);
      3: return 8'((H >> 8) & 255);
      default: return 8'(H & 255);
    endcase
  endfunction

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic rdy);
    bit pop;
    @(negedge clk);
    rx_valid = v; rx_data = d; tx_ready = rdy;
    #1;
    if (prev_v && !prev_r)
      chk(tx_valid && tx_data == prev_d, "R4 hold", int'(tx_data), int'(prev_d));
    if (fifo_rd_en) chk(!fifo_empty, "R9 pop on empty", 1, 0);
    if (mode_stream)
      chk(fifo_rd_en == (tx_valid && tx_ready), "R6 pop vs handshake", int'(fifo_rd_en), int'(tx_valid && tx_ready));
    if (tx_valid && tx_ready) got.push_back(tx_data);
    if (r_tx_valid) got_rgb.push_back(r_tx_data);
    pop = fifo_rd_en;
    prev_v = tx_valid; prev_r = tx_ready; prev_d = tx_data;
    @(posedge clk); #1;
    rx_valid = 0;
    if (pop) void'(q.pop_front());
    if (cap_on && stream_en && $urandom_range(0, 2) == 0) begin
      logic [7:0] b = 8'($urandom);
      q.push_back(b); pushed.push_back(b);
    end
    fifo_empty = (q.size() == 0);
    fifo_data  = (q.size() != 0) ? q[0] : 8'h00;
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      q.push_back(b); pushed.push_back(b);
    end
    fifo_empty = (q.size() == 0);
    fifo_data  = (q.size() != 0) ? q[0] : 8'h00;
  endtask

  task automatic run_info(input string tag);
    got.delete(); got_rgb.delete();
    step(1, 8'h01, 1'($urandom));
    for (int i = 0; i < 100 && got.size() < 5; i++) step(0, 0, 1'($urandom));
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    chk(got.size() == 5, {tag, " R2 length"}, got.size(), 5);
    chk(got_rgb.size() == 5, {tag, " R2 length rgb"}, got_rgb.size(), 5);
    for (int i = 0; i < 5 && i < got.size(); i++)
      chk(got[i] == exp_info(1, i), (i == 0) ? {tag, " R2 type gray"} : {tag, " R3 dims"}, int'(got[i]), int'(exp_info(1, i)));
    for (int i = 0; i < 5 && i < got_rgb.size(); i++)
      chk(got_rgb[i] == exp_info(2, i), (i == 0) ? {tag, " R2 type rgb"} : {tag, " R3 dims rgb"}, int'(got_rgb[i]), int'(exp_info(2, i)));
  endtask

  task automatic stop_and_drain(input bit pending);
    int rem, expn;
    cap_on = 0;
    load(6);
    mode_stream = 0;
    rem = q.size();
    step(1, 8'h0F, pending ? 1'b0 : 1'b1);
    chk(stream_en == 0, "R7 stream_en low after stop", int'(stream_en), 0);
    if (pending) begin
      for (int i = 0; i < 3; i++) begin
        step(0, 0, 0);
        chk(tx_valid == 1, "R10 pending byte kept", int'(tx_valid), 1);
      end
      step(0, 0, 1);
    end
    for (int i = 0; i < 20; i++) begin
      step(0, 0, 1);
      chk(tx_valid == 0, "R7 no tx during discard", int'(tx_valid), 0);
    end
    expn = pushed.size() - rem + 1;
    chk(q.size() == 0, "R7 fifo discarded", q.size(), 0);
    chk(got.size() == expn, "R7 byte count", got.size(), expn);
    for (int i = 0; i < got.size() && i < pushed.size(); i++)
      if (got[i] !== pushed[i]) begin
        chk(0, "R6 order", int'(got[i]), int'(pushed[i]));
        break;
      end
    chk(stream_en == 0 && fifo_rd_en == 0, "R7 back to idle", int'(stream_en), 0);
  endtask

  task automatic run_stream(input bit pending);
    got.delete(); pushed.delete(); q.delete();
    fifo_empty = 1;
    step(1, 8'h11, 0);
    chk(stream_en == 1, "R5 stream_en after start", int'(stream_en), 1);
    cap_on = 1; mode_stream = 1;
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 19);
      if (k == 0)      step(1, 8'h01, 1'($urandom));
      else if (k == 1) step(1, 8'h11, 1'($urandom));
      else if (k == 2) step(1, 8'h5A, 1'($urandom));
      else             step(0, 0, 1'($urandom));
      chk(stream_en == 1, "R8 stream kept", int'(stream_en), 1);
    end
    stop_and_drain(pending);
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #1;
    chk(stream_en == 0 && tx_valid == 0 && fifo_rd_en == 0, "R1 reset outputs",
        int'({stream_en, tx_valid, fifo_rd_en}), 0);
    rst_n = 1;
    step(0, 0, 0);
    chk(stream_en == 0 && tx_valid == 0, "R1 idle after reset", int'({stream_en, tx_valid}), 0);

    for (int i = 0; i < 30; i++) begin
      logic [7:0] b = 8'($urandom);
      if (b == 8'h01 || b == 8'h11) b = 8'hC3;
      step(1, b, 1);
      chk(stream_en == 0 && tx_valid == 0, "R8 unknown/stop ignored in idle", int'({stream_en, tx_valid}), 0);
    end

    run_info("seq1");
    run_info("seq2");

    got.delete(); got_rgb.delete();
    step(1, 8'h01, 0);
    step(1, 8'h11, 0);
    step(1, 8'h0F, 0);
    chk(stream_en == 0, "R8 start ignored during packet", int'(stream_en), 0);
    chk(tx_valid == 1 && tx_data == 8'hAA, "R4 packet held", int'(tx_data), 'hAA);
    for (int i = 0; i < 10; i++) step(0, 0, 1);
    chk(got.size() == 5 && got[0] == 8'hAA, "R2 packet after ignored cmds", got.size(), 5);
    chk(stream_en == 0, "R8 still idle", int'(stream_en), 0);

    run_stream(1);
    run_stream(0);
    run_info("after stream");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule